// File: doc/BRIEF.md
# Cutoff Distance Pair Filter Bank

This block screens particle pairs before they reach a force pipeline. A small bank of filters each keeps one resident reference particle, taken from the home cell being processed. Every clock cycle the surrounding cell set supplies one partner particle. That partner is broadcast to all filters at once. Each filter measures the squared separation between its reference and the partner, compares it with a programmable squared cutoff, and raises its own pair-valid output when the pair is close enough to need a force evaluation. The downstream per-filter queues use that flag together with the reference and partner identifiers.

Coordinates are signed fixed-point values. The distance test runs through three register stages, and the partner identifier travels through the same stages. A global stall freezes the whole pipeline. A parameter selects a reduced-precision variant of the test, which drops low magnitude bits. That variant may let a few extra pairs through, but it never drops a pair that is truly inside the cutoff. When the home cell changes, the references are invalidated and reloaded.

Top module: `pair_filter_bank`

## Requirements
- R1: On an edge with `ref_load` high, slot `ref_slot` takes the reference coordinates and identifier and becomes valid. Slot i drives `pair_hit[i]` and `pair_ref_id[i*ID_W +: ID_W]`. On an edge with `ref_clear` high, every slot becomes invalid. When `ref_clear` and `ref_load` are high on the same edge, only the loaded slot is valid afterwards. A filter whose slot is invalid never reports a hit.
- R2: A partner is captured on a non-stalled edge when `bc_valid` is high. It is tested against every valid slot in parallel. The results appear on `pair_hit` after the second non-stalled edge that follows the capture edge (three register stages). `pair_part_id` carries that partner's identifier in the same cycle. Back-to-back partners produce back-to-back results.
- R3: In the exact variant (`REDUCE_BITS` = 0), a filter hits when dx²+dy²+dz² ≤ cutoff. Here each d is the reference coordinate minus the partner coordinate, both read as signed two's complement. Equality passes. The cutoff register is written on an edge with `cut_wr` high.
- R4: The test is exact over the full coordinate range: differences up to ±65535 per axis with the default 16-bit coordinates, and a sum up to 3·65535², with no wrap.
- R5: A pair whose reference identifier equals the partner identifier is never reported.
- R6: While `stall` is high, `pair_hit`, `pair_ref_id` and `pair_part_id` hold their values and no partner is captured. Partners presented during a stall are lost.
- R7: A cycle with `bc_valid` low produces no hit in any filter, whatever the coordinates on the broadcast inputs.
- R8: With `REDUCE_BITS` = B > 0, each |d| is truncated by discarding its B low bits. The filter hits when the sum of the squared truncated magnitudes ≤ (cutoff >> 2B). Every pair that passes the R3 test also passes this one.
- R9: After reset, all slots are invalid, the cutoff is 0, `pair_hit` is all zero and `pair_part_id` is 0.
- R10: `pair_ref_id` reports the identifier the slot held when the partner was captured. A reload of that slot while the pair is in flight does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes capture and all pipeline stages |
| cut_wr | input | 1 | Write strobe for the squared cutoff |
| cut_val | input | CUT_W (2·COORD_W+2) | Squared cutoff value |
| ref_clear | input | 1 | Invalidates all reference slots |
| ref_load | input | 1 | Writes one reference slot |
| ref_slot | input | SLOT_W | Slot index for a load |
| ref_x | input | COORD_W | Reference x, signed |
| ref_y | input | COORD_W | Reference y, signed |
| ref_z | input | COORD_W | Reference z, signed |
| ref_id | input | ID_W | Reference identifier |
| bc_valid | input | 1 | Broadcast partner present |
| bc_x | input | COORD_W | Partner x, signed |
| bc_y | input | COORD_W | Partner y, signed |
| bc_z | input | COORD_W | Partner z, signed |
| bc_id | input | ID_W | Partner identifier |
| pair_hit | output | NUM_FILT | Per-filter pair-valid flag |
| pair_ref_id | output | NUM_FILT·ID_W | Per-filter reference identifier of the reported pair |
| pair_part_id | output | ID_W | Partner identifier of the reported pairs |

## Verification
Every result is due after the second non-stalled edge that follows its capture edge. The bench counts only edges on which `stall` was low. Each broadcast it drives is tagged with the count at which its result must appear, and the result is compared at the falling edge after that count is reached. Edges on which nothing is due must show no hit. Stalled edges do not advance the count, so partners in flight across a stall are still compared at the right moment. The held outputs are compared during every stalled cycle. A second instance with four truncated bits runs on the same stimulus, so the reduced test is compared against its own expected masks and against the exact masks in the same cycle.

// File: rtl/pf_pkg.sv
package pf_pkg;

   // register stages between broadcast capture and pair_hit
   localparam int PF_STAGES = 3;
   localparam int PF_AXES   = 3;

   typedef enum logic {
      PF_EXACT = 1'b0,
      PF_TRUNC = 1'b1
   } pf_prec_e;

   // squared-cutoff width: square of a COORD_W-bit magnitude, times three axes
   function automatic int pf_cut_width(input int coord_w);
      return 2 * coord_w + 2;
   endfunction

   function automatic pf_prec_e pf_prec_of(input int drop_bits);
      return (drop_bits == 0) ? PF_EXACT : PF_TRUNC;
   endfunction

endpackage

// File: rtl/pf_ref_store.sv
module pf_ref_store #(
   parameter int NUM_FILT = 8,
   parameter int COORD_W  = 16,
   parameter int ID_W     = 12,
   localparam int SLOT_W  = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        load,
   input  logic [SLOT_W-1:0]           slot,
   input  logic [COORD_W-1:0]          in_x,
   input  logic [COORD_W-1:0]          in_y,
   input  logic [COORD_W-1:0]          in_z,
   input  logic [ID_W-1:0]             in_id,
   output logic [NUM_FILT*COORD_W-1:0] rx,
   output logic [NUM_FILT*COORD_W-1:0] ry,
   output logic [NUM_FILT*COORD_W-1:0] rz,
   output logic [NUM_FILT*ID_W-1:0]    rid,
   output logic [NUM_FILT-1:0]         vld
);

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_slot
      logic hit_slot;
      assign hit_slot = load && (slot == SLOT_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[i]                    <= 1'b0;
            rx[i*COORD_W +: COORD_W]  <= '0;
            ry[i*COORD_W +: COORD_W]  <= '0;
            rz[i*COORD_W +: COORD_W]  <= '0;
            rid[i*ID_W +: ID_W]       <= '0;
         end else begin
            if (hit_slot) begin
               vld[i]                   <= 1'b1;
               rx[i*COORD_W +: COORD_W] <= in_x;
               ry[i*COORD_W +: COORD_W] <= in_y;
               rz[i*COORD_W +: COORD_W] <= in_z;
               rid[i*ID_W +: ID_W]      <= in_id;
            end else if (clear) begin
               vld[i] <= 1'b0;
            end
         end
      end
   end

   // R1: a clear without a load leaves no slot valid
   assert_clear_empties_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !load) |=> (vld == '0));

   // R1: a load always leaves the addressed slot valid
   assert_load_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (int'(slot) < NUM_FILT)) |=> vld[$past(slot)]);

endmodule

// File: rtl/pf_bcast_pipe.sv
module pf_bcast_pipe
   import pf_pkg::*;
#(
   parameter int ID_W   = 12,
   parameter int STAGES = PF_STAGES
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            in_valid,
   input  logic [ID_W-1:0] in_id,
   output logic            out_valid,
   output logic [ID_W-1:0] out_id
);

   logic            v_q  [STAGES];
   logic [ID_W-1:0] id_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            v_q[s]  <= 1'b0;
            id_q[s] <= '0;
         end
      end else if (adv) begin
         v_q[0]  <= in_valid;
         id_q[0] <= in_id;
         for (int s = 1; s < STAGES; s++) begin
            v_q[s]  <= v_q[s-1];
            id_q[s] <= id_q[s-1];
         end
      end
   end

   assign out_valid = v_q[STAGES-1];
   assign out_id    = id_q[STAGES-1];

   // R6: a stalled edge moves nothing out of the partner pipeline
   assert_partner_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(out_valid) && $stable(out_id)));

endmodule

// File: rtl/pf_dist_lane.sv
module pf_dist_lane
   import pf_pkg::*;
#(
   parameter int COORD_W     = 16,
   parameter int ID_W        = 12,
   parameter int REDUCE_BITS = 0,
   localparam int CUT_W      = pf_cut_width(COORD_W),
   localparam int DIFF_W     = COORD_W + 1,
   localparam int RMAG_W     = COORD_W - REDUCE_BITS,
   localparam int SQ_W       = 2 * RMAG_W,
   localparam int SUM_W      = SQ_W + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adv,
   input  logic               bc_valid,
   input  logic [COORD_W-1:0] bc_x,
   input  logic [COORD_W-1:0] bc_y,
   input  logic [COORD_W-1:0] bc_z,
   input  logic [ID_W-1:0]    bc_id,
   input  logic               ref_vld,
   input  logic [COORD_W-1:0] ref_x,
   input  logic [COORD_W-1:0] ref_y,
   input  logic [COORD_W-1:0] ref_z,
   input  logic [ID_W-1:0]    ref_id,
   input  logic [CUT_W-1:0]   cut_sq,
   output logic               hit,
   output logic [ID_W-1:0]    hit_ref_id
);

   logic [COORD_W-1:0] ref_c [PF_AXES];
   logic [COORD_W-1:0] bc_c  [PF_AXES];
   assign ref_c[0] = ref_x;
   assign ref_c[1] = ref_y;
   assign ref_c[2] = ref_z;
   assign bc_c[0]  = bc_x;
   assign bc_c[1]  = bc_y;
   assign bc_c[2]  = bc_z;

   // ---------------- stage 1: signed differences ----------------
   logic [DIFF_W-1:0] d_c  [PF_AXES];
   logic [DIFF_W-1:0] s1_d [PF_AXES];
   logic              s1_ok;
   logic [ID_W-1:0]   s1_rid;
   logic              pair_ok;

   always_comb begin
      for (int a = 0; a < PF_AXES; a++) begin
         d_c[a] = DIFF_W'($signed({ref_c[a][COORD_W-1], ref_c[a]})
                        - $signed({bc_c[a][COORD_W-1], bc_c[a]}));
      end
   end

   assign pair_ok = bc_valid && ref_vld && (ref_id != bc_id);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < PF_AXES; a++) s1_d[a] <= '0;
         s1_ok  <= 1'b0;
         s1_rid <= '0;
      end else if (adv) begin
         for (int a = 0; a < PF_AXES; a++) s1_d[a] <= d_c[a];
         s1_ok  <= pair_ok;
         s1_rid <= ref_id;
      end
   end

   // ---------------- stage 2: magnitudes and squares ----------------
   logic [COORD_W-1:0] mag   [PF_AXES];
   logic [RMAG_W-1:0]  m_use [PF_AXES];
   logic [CUT_W-1:0]   lim;
   logic [SQ_W-1:0]    s2_sq [PF_AXES];
   logic               s2_ok;
   logic [ID_W-1:0]    s2_rid;

   always_comb begin
      for (int a = 0; a < PF_AXES; a++) begin
         mag[a] = COORD_W'(s1_d[a][DIFF_W-1] ? (~s1_d[a] + 1'b1) : s1_d[a]);
      end
   end

   if (pf_prec_of(REDUCE_BITS) == PF_EXACT) begin : g_exact
      always_comb begin
         for (int a = 0; a < PF_AXES; a++) m_use[a] = mag[a];
      end
      assign lim = cut_sq;
   end else begin : g_trunc
      // truncated magnitudes never exceed the true ones, so the test only widens
      always_comb begin
         for (int a = 0; a < PF_AXES; a++) m_use[a] = mag[a][COORD_W-1:REDUCE_BITS];
      end
      assign lim = cut_sq >> (2 * REDUCE_BITS);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < PF_AXES; a++) s2_sq[a] <= '0;
         s2_ok  <= 1'b0;
         s2_rid <= '0;
      end else if (adv) begin
         for (int a = 0; a < PF_AXES; a++) s2_sq[a] <= SQ_W'(m_use[a]) * SQ_W'(m_use[a]);
         s2_ok  <= s1_ok;
         s2_rid <= s1_rid;
      end
   end

   // ---------------- stage 3: sum and cutoff compare ----------------
   logic [SUM_W-1:0] sum_c;
   assign sum_c = SUM_W'(s2_sq[0]) + SUM_W'(s2_sq[1]) + SUM_W'(s2_sq[2]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit        <= 1'b0;
         hit_ref_id <= '0;
      end else if (adv) begin
         hit        <= s2_ok && (CUT_W'(sum_c) <= lim);
         hit_ref_id <= s2_rid;
      end
   end

   // R6: a stalled edge holds this filter's result
   assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> ($stable(hit) && $stable(hit_ref_id)));

endmodule

// File: rtl/pair_filter_bank.sv
module pair_filter_bank
   import pf_pkg::*;
#(
   parameter int NUM_FILT    = 8,
   parameter int COORD_W     = 16,
   parameter int ID_W        = 12,
   parameter int REDUCE_BITS = 0,
   localparam int SLOT_W     = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
   localparam int CUT_W      = pf_cut_width(COORD_W)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stall,
   input  logic                     cut_wr,
   input  logic [CUT_W-1:0]         cut_val,
   input  logic                     ref_clear,
   input  logic                     ref_load,
   input  logic [SLOT_W-1:0]        ref_slot,
   input  logic [COORD_W-1:0]       ref_x,
   input  logic [COORD_W-1:0]       ref_y,
   input  logic [COORD_W-1:0]       ref_z,
   input  logic [ID_W-1:0]          ref_id,
   input  logic                     bc_valid,
   input  logic [COORD_W-1:0]       bc_x,
   input  logic [COORD_W-1:0]       bc_y,
   input  logic [COORD_W-1:0]       bc_z,
   input  logic [ID_W-1:0]          bc_id,
   output logic [NUM_FILT-1:0]      pair_hit,
   output logic [NUM_FILT*ID_W-1:0] pair_ref_id,
   output logic [ID_W-1:0]          pair_part_id
);

   // elaboration-time parameter checks
   if (NUM_FILT < 1) begin : g_bad_count
      $error("pair_filter_bank: NUM_FILT must be at least 1");
   end
   if (COORD_W < 2 || ID_W < 1) begin : g_bad_width
      $error("pair_filter_bank: COORD_W must be >= 2 and ID_W >= 1");
   end
   if (REDUCE_BITS < 0 || REDUCE_BITS >= COORD_W) begin : g_bad_reduce
      $error("pair_filter_bank: REDUCE_BITS must lie in [0, COORD_W)");
   end
   if (PF_STAGES != 3) begin : g_bad_stages
      $error("pair_filter_bank: lane datapath is built for three stages");
   end

   logic adv;
   assign adv = !stall;

   logic [CUT_W-1:0] cut_q;
   always_ff @(posedge clk) begin
      if (!rst_n)      cut_q <= '0;
      else if (cut_wr) cut_q <= cut_val;
   end

   logic [NUM_FILT*COORD_W-1:0] rx, ry, rz;
   logic [NUM_FILT*ID_W-1:0]    rid;
   logic [NUM_FILT-1:0]         rvld;

   pf_ref_store #(
      .NUM_FILT (NUM_FILT),
      .COORD_W  (COORD_W),
      .ID_W     (ID_W)
   ) u_refs (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (ref_clear),
      .load  (ref_load),
      .slot  (ref_slot),
      .in_x  (ref_x),
      .in_y  (ref_y),
      .in_z  (ref_z),
      .in_id (ref_id),
      .rx    (rx),
      .ry    (ry),
      .rz    (rz),
      .rid   (rid),
      .vld   (rvld)
   );

   logic part_vld;

   pf_bcast_pipe #(
      .ID_W   (ID_W),
      .STAGES (PF_STAGES)
   ) u_bcast (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (adv),
      .in_valid  (bc_valid),
      .in_id     (bc_id),
      .out_valid (part_vld),
      .out_id    (pair_part_id)
   );

   for (genvar i = 0; i < NUM_FILT; i++) begin : g_lane
      pf_dist_lane #(
         .COORD_W     (COORD_W),
         .ID_W        (ID_W),
         .REDUCE_BITS (REDUCE_BITS)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .adv        (adv),
         .bc_valid   (bc_valid),
         .bc_x       (bc_x),
         .bc_y       (bc_y),
         .bc_z       (bc_z),
         .bc_id      (bc_id),
         .ref_vld    (rvld[i]),
         .ref_x      (rx[i*COORD_W +: COORD_W]),
         .ref_y      (ry[i*COORD_W +: COORD_W]),
         .ref_z      (rz[i*COORD_W +: COORD_W]),
         .ref_id     (rid[i*ID_W +: ID_W]),
         .cut_sq     (cut_q),
         .hit        (pair_hit[i]),
         .hit_ref_id (pair_ref_id[i*ID_W +: ID_W])
      );

      // R5: a reported pair never pairs a particle with itself
      assert_no_self_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
         pair_hit[i] |-> (pair_ref_id[i*ID_W +: ID_W] != pair_part_id));
   end

   // R7: any hit belongs to a partner that was actually broadcast
   assert_hit_has_partner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (|pair_hit) |-> part_vld);

   // R9: the first edge out of reset shows no hit
   assert_reset_quiet_R9: assert property (@(posedge clk)
      !rst_n |=> (pair_hit == '0));

endmodule

// File: tb/pair_filter_bank_test.sv
`timescale 1ns/1ps
module pair_filter_bank_test;

   localparam int N    = 8;
   localparam int CW   = 16;
   localparam int IW   = 12;
   localparam int RB   = 4;
   localparam int SW   = 3;
   localparam int CUTW = 2 * CW + 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            stall = 1'b0;
   logic            cut_wr = 1'b0;
   logic [CUTW-1:0] cut_val = '0;
   logic            ref_clear = 1'b0;
   logic            ref_load = 1'b0;
   logic [SW-1:0]   ref_slot = '0;
   logic [CW-1:0]   ref_x = '0, ref_y = '0, ref_z = '0;
   logic [IW-1:0]   ref_id = '0;
   logic            bc_valid = 1'b0;
   logic [CW-1:0]   bc_x = '0, bc_y = '0, bc_z = '0;
   logic [IW-1:0]   bc_id = '0;

   logic [N-1:0]    hit_f, hit_r;
   logic [N*IW-1:0] rid_f, rid_r;
   logic [IW-1:0]   pid_f, pid_r;

   always #2 clk = ~clk;   // 250 MHz

   pair_filter_bank #(.NUM_FILT(N), .COORD_W(CW), .ID_W(IW), .REDUCE_BITS(0)) uut (
      .clk(clk), .rst_n(rst_n), .stall(stall), .cut_wr(cut_wr), .cut_val(cut_val),
      .ref_clear(ref_clear), .ref_load(ref_load), .ref_slot(ref_slot),
      .ref_x(ref_x), .ref_y(ref_y), .ref_z(ref_z), .ref_id(ref_id),
      .bc_valid(bc_valid), .bc_x(bc_x), .bc_y(bc_y), .bc_z(bc_z), .bc_id(bc_id),
      .pair_hit(hit_f), .pair_ref_id(rid_f), .pair_part_id(pid_f));

   pair_filter_bank #(.NUM_FILT(N), .COORD_W(CW), .ID_W(IW), .REDUCE_BITS(RB)) uut_lo (
      .clk(clk), .rst_n(rst_n), .stall(stall), .cut_wr(cut_wr), .cut_val(cut_val),
      .ref_clear(ref_clear), .ref_load(ref_load), .ref_slot(ref_slot),
      .ref_x(ref_x), .ref_y(ref_y), .ref_z(ref_z), .ref_id(ref_id),
      .bc_valid(bc_valid), .bc_x(bc_x), .bc_y(bc_y), .bc_z(bc_z), .bc_id(bc_id),
      .pair_hit(hit_r), .pair_ref_id(rid_r), .pair_part_id(pid_r));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   longint m_x [N], m_y [N], m_z [N];
   int     m_id [N];
   bit     m_v [N];
   longint m_cut = 0;

   typedef struct {
      longint          due;
      logic [N-1:0]    mf;
      logic [N-1:0]    mr;
      logic [N*IW-1:0] rids;
      logic [IW-1:0]   pid;
      string           tag;
   } item_t;
   item_t q[$];

   longint adv = 0;
   always @(posedge clk) if (rst_n && !stall) adv <= adv + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint absl(input longint v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic bit hit_full(input int l, input longint x, input longint y,
                                   input longint z, input int id);
      longint dx, dy, dz;
      dx = m_x[l] - x; dy = m_y[l] - y; dz = m_z[l] - z;
      return m_v[l] && (m_id[l] != id) && (dx*dx + dy*dy + dz*dz <= m_cut);
   endfunction

   function automatic bit hit_red(input int l, input longint x, input longint y,
                                  input longint z, input int id);
      longint ax, ay, az;
      ax = absl(m_x[l] - x) >>> RB;
      ay = absl(m_y[l] - y) >>> RB;
      az = absl(m_z[l] - z) >>> RB;
      return m_v[l] && (m_id[l] != id) && (ax*ax + ay*ay + az*az <= (m_cut >>> (2*RB)));
   endfunction

   task automatic begin_cycle();
      @(negedge clk);
      stall = 1'b0; bc_valid = 1'b0; ref_load = 1'b0; ref_clear = 1'b0; cut_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin_cycle();
   endtask

   task automatic set_cut(input longint v);
      begin_cycle();
      cut_wr = 1'b1; cut_val = CUTW'(v); m_cut = v;
   endtask

   task automatic load_ref(input int s, input longint x, input longint y,
                           input longint z, input int id);
      begin_cycle();
      ref_load = 1'b1; ref_slot = SW'(s);
      ref_x = CW'(x); ref_y = CW'(y); ref_z = CW'(z); ref_id = IW'(id);
      m_x[s] = x; m_y[s] = y; m_z[s] = z; m_id[s] = id; m_v[s] = 1'b1;
   endtask

   task automatic clear_refs(input bit with_load, input int s, input longint x,
                             input longint y, input longint z, input int id);
      begin_cycle();
      ref_clear = 1'b1;
      for (int l = 0; l < N; l++) m_v[l] = 1'b0;
      if (with_load) begin
         ref_load = 1'b1; ref_slot = SW'(s);
         ref_x = CW'(x); ref_y = CW'(y); ref_z = CW'(z); ref_id = IW'(id);
         m_x[s] = x; m_y[s] = y; m_z[s] = z; m_id[s] = id; m_v[s] = 1'b1;
      end
   endtask

   // driver: one broadcast cycle, expected result pushed to the scoreboard
   task automatic bcast(input bit vld, input longint x, input longint y, input longint z,
                        input int id, input string tag);
      item_t it;
      begin_cycle();
      bc_valid = vld; bc_x = CW'(x); bc_y = CW'(y); bc_z = CW'(z); bc_id = IW'(id);
      it.due = adv + 3;   // capture edge plus two more advancing edges
      it.tag = tag;
      it.pid = IW'(id);
      for (int l = 0; l < N; l++) begin
         it.mf[l] = vld && hit_full(l, x, y, z, id);
         it.mr[l] = vld && hit_red(l, x, y, z, id);
         it.rids[l*IW +: IW] = IW'(m_id[l]);
      end
      q.push_back(it);
   endtask

   // stalled cycles with a live-looking partner that must be ignored
   task automatic stall_hold(input int n, input longint x, input int id);
      logic [N-1:0]  hf, hr;
      logic [IW-1:0] hp;
      hf = '0; hr = '0; hp = '0;
      for (int k = 0; k < n; k++) begin
         begin_cycle();
         stall = 1'b1; bc_valid = 1'b1;
         bc_x = CW'(x); bc_y = '0; bc_z = '0; bc_id = IW'(id);
         if (k == 0) begin
            hf = hit_f; hr = hit_r; hp = pid_f;
         end else begin
            chk(hit_f == hf, "R6", "held pair_hit", hit_f, hf);
            chk(hit_r == hr, "R6", "held pair_hit reduced", hit_r, hr);
            chk(pid_f == hp, "R6", "held pair_part_id", pid_f, hp);
         end
      end
   endtask

   // monitor: pops scoreboard items when their result is due
   initial begin : monitor
      longint seen;
      item_t  it;
      seen = 0;
      wait (rst_n);
      forever begin
         @(negedge clk);
         if (adv != seen) begin
            seen = adv;
            if (q.size() > 0 && q[0].due == adv) begin
               it = q.pop_front();
               chk(hit_f == it.mf, it.tag, "pair_hit exact", hit_f, it.mf);
               chk(hit_r == it.mr, it.tag, "pair_hit reduced (R8)", hit_r, it.mr);
               chk((it.mf & ~hit_r) == '0, "R8", "reduced test dropped a true pair",
                   hit_r, it.mf);
               if (it.mf != '0)
                  chk(pid_f == it.pid, "R2", "pair_part_id", pid_f, it.pid);
               for (int l = 0; l < N; l++) begin
                  if (it.mf[l])
                     chk(rid_f[l*IW +: IW] == it.rids[l*IW +: IW], "R10", "pair_ref_id",
                         rid_f[l*IW +: IW], it.rids[l*IW +: IW]);
               end
            end else begin
               chk(hit_f == '0 && hit_r == '0, "R7", "hit with nothing due",
                   hit_f, 0);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stimulus
      for (int l = 0; l < N; l++) begin
         m_x[l] = 0; m_y[l] = 0; m_z[l] = 0; m_id[l] = 0; m_v[l] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk(hit_f == '0, "R9", "pair_hit after reset", hit_f, 0);
      chk(pid_f == '0, "R9", "pair_part_id after reset", pid_f, 0);

      // R9: cutoff resets to 0, only zero separation passes
      load_ref(0, 5, 0, 0, 1);
      bcast(1, 5, 0, 0, 2, "R9");
      bcast(1, 6, 0, 0, 2, "R9");
      idle(3);

      // R3 / R2: row of references, cutoff 100
      set_cut(10000);
      for (int l = 0; l < N; l++) load_ref(l, l * 40, 0, 0, 100 + l);
      bcast(1, 0, 0, 0, 5, "R2");
      bcast(1, 140, 0, 0, 6, "R3");   // slot 1 at exactly the cutoff
      bcast(1, 141, 0, 0, 7, "R3");   // slot 1 just outside
      bcast(1, 100, 60, -80, 8, "R3");
      bcast(1, 80, 0, 0, 102, "R5");  // same id as slot 2
      bcast(0, 80, 0, 0, 9, "R7");    // not valid
      idle(3);

      // R6: hold a nonzero result through a stall, garbage partner ignored
      bcast(1, 60, 0, 0, 11, "R6");
      idle(2);
      stall_hold(4, 40, 12);
      idle(3);
      // R6: partner in flight across a stall
      bcast(1, 200, 0, 0, 13, "R6");
      stall_hold(3, 120, 14);
      idle(4);

      // R10: reload a slot while its pair is in flight
      bcast(1, 0, 0, 0, 15, "R10");
      load_ref(0, 0, 0, 0, 500);
      bcast(1, 0, 0, 0, 16, "R10");
      idle(3);

      // R2: random back-to-back broadcasts
      set_cut(22500);
      for (int l = 0; l < N; l++) load_ref(l, l * 60 - 200, (l % 3) * 50, 0, 200 + l);
      for (int k = 0; k < 300; k++) begin
         bcast(($urandom_range(9) != 0),
               longint'($urandom_range(600)) - 300,
               longint'($urandom_range(400)) - 200,
               longint'($urandom_range(300)) - 150,
               int'($urandom_range(4095)), "R2");
      end
      idle(3);

      // R1: clear, then clear together with a load
      clear_refs(1'b0, 0, 0, 0, 0, 0);
      bcast(1, 0, 0, 0, 1, "R1");
      clear_refs(1'b1, 3, 10, 10, 10, 33);
      bcast(1, 10, 10, 10, 1, "R1");
      idle(3);

      // R4: extreme coordinates
      clear_refs(1'b1, 0, 32767, 32767, 32767, 1);
      load_ref(1, -32768, -32768, -32768, 2);
      set_cut(64'h3_FFFF_FFFF);
      bcast(1, -32768, -32768, -32768, 3, "R4");
      idle(3);
      set_cut(3 * 65535 * 65535);
      bcast(1, -32768, -32768, -32768, 3, "R4");
      idle(3);
      set_cut(3 * 65535 * 65535 - 1);
      bcast(1, -32768, -32768, -32768, 3, "R4");
      idle(3);

      // R8: truncation lets through a near miss, never a far one
      clear_refs(1'b1, 0, 0, 0, 0, 1);
      set_cut(0);
      bcast(1, 15, 0, 0, 9, "R8");
      bcast(1, -15, 15, -15, 9, "R8");
      bcast(1, 16, 0, 0, 9, "R8");
      idle(4);

      chk(q.size() == 0, "R2", "scoreboard drained", q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule